// File: doc/BRIEF.md
# Four-Register Two-Operand Processor Core

This block is a small single-cycle processor core. It holds four general registers and a program counter. Every clock edge it completes one instruction, read from an external instruction store. The core presents the program counter as the instruction address. The store returns two words: the instruction word at that address, and the word that follows it, which is the address or target field. Data memory sits outside the core. Loads read it combinationally within the same cycle. Stores raise a write strobe for exactly the cycle in which they execute.

Each instruction has a 2-bit class, a 1-bit modifier and two 2-bit register selectors. The class and modifier together pick one of eight operations: memory load, memory store, register copy, register complement, add, subtract, jump, and jump on condition. The destination selector names the register that is written, which is also the first arithmetic operand. The source selector names the second operand. Forms that use the trailing address word step the program counter by two. Register-only forms step it by one.

Top module: `quad_reg_core`

## Requirements
- R1: Instruction word bits [6:5] are the class, bit [4] the modifier, bits [3:2] the destination selector D and bits [1:0] the source selector S. With class 0 and modifier 0 (load), register D takes the data-memory word at address A, where A is the word after the instruction. The program counter then advances by 2.
- R2: With class 0 and modifier 1 (store), the core drives the write strobe high for that one cycle, with address A and data equal to register S. No register changes, and the program counter advances by 2.
- R3: With class 1 and modifier 0 (copy), register D takes register S, and the program counter advances by 1.
- R4: With class 1 and modifier 1 (complement), register D takes the bitwise inverse of register S, and the program counter advances by 1.
- R5: With class 2 and modifier 0 (add), register D takes D+S modulo 2^W, and the program counter advances by 1.
- R6: With class 2 and modifier 1 (subtract), register D takes D-S modulo 2^W, and the program counter advances by 1.
- R7: With class 3 and modifier 0 (jump), the program counter takes A.
- R8: With class 3 and modifier 1 (conditional jump), the program counter takes A when the condition input is 1, and otherwise advances by 2.
- R9: A synchronous reset clears the program counter and all four registers.
- R10: The write strobe stays low on every instruction other than store.
- R11: Only register D is written by a writing instruction. The other three registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr_o | output | AW | Program counter, used as the instruction address |
| imem_word_i | input | 7 | Instruction word at the program counter |
| imem_ext_i | input | AW | Word after the instruction (address or target A) |
| cond_i | input | 1 | Condition examined by the conditional jump |
| dmem_addr_o | output | AW | Data-memory address (A) |
| dmem_wdata_o | output | W | Store data (register S) |
| dmem_we_o | output | 1 | One-cycle write strobe |
| dmem_rdata_i | input | W | Data-memory word at dmem_addr_o, combinational |

## Verification
The store outputs are combinational from the current instruction and the registers. The bench therefore samples them at the falling edge inside the store cycle, before the edge that retires it. Register results and the new program counter take effect at the first rising edge after the instruction is presented. The bench checks them at the next falling edge: directly for the program counter, and for registers through the store instructions that follow. Register contents are visible only through stores. Each arithmetic or transfer case therefore runs a fixed sequence of four loads, one operation and four stores. The expected register set is computed in the bench, and the counter is checked after every instruction.

// File: rtl/qrc_pkg.sv
package qrc_pkg;

    typedef enum logic [2:0] {
        K_LOAD  = 3'd0,
        K_STORE = 3'd1,
        K_COPY  = 3'd2,
        K_INV   = 3'd3,
        K_ADD   = 3'd4,
        K_SUB   = 3'd5,
        K_JMP   = 3'd6,
        K_JCOND = 3'd7
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [1:0] dst;
        logic [1:0] src;
        logic       wr_reg;
    } dec_t;

    localparam int INSN_W = 7;

endpackage

// File: rtl/qrc_decode.sv
module qrc_decode
    import qrc_pkg::*;
(
    input  logic [INSN_W-1:0] instr_i,
    output dec_t              dec_o
);

    logic [1:0] cls;
    logic       mdf;

    assign cls = instr_i[6:5];
    assign mdf = instr_i[4];

    always_comb begin
        dec_o.dst    = instr_i[3:2];
        dec_o.src    = instr_i[1:0];
        dec_o.wr_reg = 1'b0;
        dec_o.kind   = K_COPY;
        case ({cls, mdf})
            3'b000: begin dec_o.kind = K_LOAD;  dec_o.wr_reg = 1'b1; end
            3'b001: begin dec_o.kind = K_STORE;                      end
            3'b010: begin dec_o.kind = K_COPY;  dec_o.wr_reg = 1'b1; end
            3'b011: begin dec_o.kind = K_INV;   dec_o.wr_reg = 1'b1; end
            3'b100: begin dec_o.kind = K_ADD;   dec_o.wr_reg = 1'b1; end
            3'b101: begin dec_o.kind = K_SUB;   dec_o.wr_reg = 1'b1; end
            3'b110: begin dec_o.kind = K_JMP;                        end
            default: begin dec_o.kind = K_JCOND;                     end
        endcase
    end

endmodule

// File: rtl/qrc_alu.sv
module qrc_alu
    import qrc_pkg::*;
#(
    parameter int W = 8
) (
    input  kind_e        kind_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] mem_i,
    output logic [W-1:0] res_o
);

    always_comb begin
        case (kind_i)
            K_LOAD:  res_o = mem_i;
            K_INV:   res_o = ~b_i;
            K_ADD:   res_o = a_i + b_i;
            K_SUB:   res_o = a_i - b_i;
            default: res_o = b_i;
        endcase
    end

endmodule

// File: rtl/qrc_regfile.sv
module qrc_regfile #(
    parameter  int W    = 8,
    parameter  int NREG = 4,
    localparam int SW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic [SW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [SW-1:0] raddr_a_i,
    input  logic [SW-1:0] raddr_b_i,
    output logic [W-1:0]  rdata_a_o,
    output logic [W-1:0]  rdata_b_o
);

    logic [NREG-1:0][W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d = '0;
        end else if (we_i) begin
            regs_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign rdata_a_o = regs_q[raddr_a_i];
    assign rdata_b_o = regs_q[raddr_b_i];

    // R9
    regs_cleared_chk: assert property (@(posedge clk) rst |=> (regs_q == '0));

    // R2
    no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(regs_q));

    for (genvar g = 0; g < NREG; g++) begin : g_hold
        // R11
        other_reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!we_i || (waddr_i != SW'(g))) |=> $stable(regs_q[g]));
    end

endmodule

// File: rtl/qrc_pc.sv
module qrc_pc
    import qrc_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  kind_e         kind_i,
    input  logic          cond_i,
    input  logic [AW-1:0] target_i,
    output logic [AW-1:0] pc_o
);

    logic [AW-1:0] pc_d, pc_q;

    always_comb begin
        pc_d = pc_q + AW'(1);
        case (kind_i)
            K_LOAD, K_STORE: pc_d = pc_q + AW'(2);
            K_JMP:           pc_d = target_i;
            K_JCOND:         pc_d = cond_i ? target_i : pc_q + AW'(2);
            default:         pc_d = pc_q + AW'(1);
        endcase
        if (rst) pc_d = '0;
    end

    always_ff @(posedge clk) begin
        pc_q <= pc_d;
    end

    assign pc_o = pc_q;

    // R9
    pc_reset_chk: assert property (@(posedge clk) rst |=> (pc_q == '0));

    // R3
    short_step_chk: assert property (@(posedge clk) disable iff (rst)
        (kind_i inside {K_COPY, K_INV, K_ADD, K_SUB}) |=> (pc_q == $past(pc_q) + AW'(1)));

    // R1
    long_step_chk: assert property (@(posedge clk) disable iff (rst)
        ((kind_i inside {K_LOAD, K_STORE}) || (kind_i == K_JCOND && !cond_i))
        |=> (pc_q == $past(pc_q) + AW'(2)));

    // R7
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        ((kind_i == K_JMP) || (kind_i == K_JCOND && cond_i)) |=> (pc_q == $past(target_i)));

endmodule

// File: rtl/quad_reg_core.sv
module quad_reg_core
    import qrc_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic [AW-1:0]     imem_addr_o,
    input  logic [INSN_W-1:0] imem_word_i,
    input  logic [AW-1:0]     imem_ext_i,
    input  logic              cond_i,
    output logic [AW-1:0]     dmem_addr_o,
    output logic [W-1:0]      dmem_wdata_o,
    output logic              dmem_we_o,
    input  logic [W-1:0]      dmem_rdata_i
);

    localparam int NREG = 4;

    dec_t         dec;
    logic [W-1:0] opnd_a, opnd_b, result;

    qrc_decode u_dec (
        .instr_i (imem_word_i),
        .dec_o   (dec)
    );

    qrc_regfile #(.W(W), .NREG(NREG)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .we_i      (dec.wr_reg),
        .waddr_i   (dec.dst),
        .wdata_i   (result),
        .raddr_a_i (dec.dst),
        .raddr_b_i (dec.src),
        .rdata_a_o (opnd_a),
        .rdata_b_o (opnd_b)
    );

    qrc_alu #(.W(W)) u_alu (
        .kind_i (dec.kind),
        .a_i    (opnd_a),
        .b_i    (opnd_b),
        .mem_i  (dmem_rdata_i),
        .res_o  (result)
    );

    qrc_pc #(.AW(AW)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .kind_i   (dec.kind),
        .cond_i   (cond_i),
        .target_i (imem_ext_i),
        .pc_o     (imem_addr_o)
    );

    assign dmem_addr_o  = imem_ext_i;
    assign dmem_wdata_o = opnd_b;
    assign dmem_we_o    = (dec.kind == K_STORE);

    // R10
    strobe_only_store_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we_o |-> (imem_word_i[6:4] == 3'b001));

    // R2
    store_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (imem_word_i[6:4] == 3'b001) |-> dmem_we_o);

endmodule

// File: tb/quad_reg_core_tb.sv
module quad_reg_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cond = 1'b0;
    logic [AW-1:0] imem_addr;
    logic [6:0]    imem_word;
    logic [AW-1:0] imem_ext;
    logic [AW-1:0] dmem_addr;
    logic [W-1:0]  dmem_wdata;
    logic          dmem_we;
    logic [W-1:0]  dmem_rdata;

    logic [7:0] prog [256];
    logic [7:0] dmem [256];

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign imem_word  = prog[imem_addr][6:0];
    assign imem_ext   = prog[8'(imem_addr + 8'd1)];
    assign dmem_rdata = dmem[dmem_addr];

    quad_reg_core #(.W(W), .AW(AW)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .imem_addr_o  (imem_addr),
        .imem_word_i  (imem_word),
        .imem_ext_i   (imem_ext),
        .cond_i       (cond),
        .dmem_addr_o  (dmem_addr),
        .dmem_wdata_o (dmem_wdata),
        .dmem_we_o    (dmem_we),
        .dmem_rdata_i (dmem_rdata)
    );

    function automatic logic [7:0] enc(input int cls, input int mdf, input int d, input int s);
        return {1'b0, 2'(cls), 1'(mdf), 2'(d), 2'(s)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    logic [7:0] init_v [4];

    // loads R0..R3, runs one register operation, then stores R0..R3
    task automatic run_case(input int cls, input int mdf, input int d, input int s);
        logic [7:0] exp_v [4];
        for (int i = 0; i < 4; i++) begin
            prog[2*i]       = enc(0, 0, i, 0);
            prog[2*i+1]     = 8'h80 + 8'(i);
            dmem[8'h80 + i] = init_v[i];
            prog[9+2*i]     = enc(0, 1, 0, i);
            prog[10+2*i]    = 8'h90 + 8'(i);
        end
        prog[8] = enc(cls, mdf, d, s);
        do_reset();
        for (int i = 0; i < 4; i++) begin
            chk("R10 no strobe on load", {31'd0, dmem_we}, 32'd0);
            @(posedge clk);
            @(negedge clk);
            chk("R1 load step", {24'd0, imem_addr}, 32'(2*(i+1)));
        end
        chk("R10 no strobe on register op", {31'd0, dmem_we}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R3 short step", {24'd0, imem_addr}, 32'd9);
        for (int i = 0; i < 4; i++) exp_v[i] = init_v[i];
        case ({cls[1:0], mdf[0]})
            3'b010: exp_v[d] = init_v[s];
            3'b011: exp_v[d] = ~init_v[s];
            3'b100: exp_v[d] = 8'(init_v[d] + init_v[s]);
            default: exp_v[d] = 8'(init_v[d] - init_v[s]);
        endcase
        for (int i = 0; i < 4; i++) begin
            chk("R2 store strobe", {31'd0, dmem_we}, 32'd1);
            chk("R2 store address", {24'd0, dmem_addr}, 32'h90 + 32'(i));
            case ({cls[1:0], mdf[0]})
                3'b010: chk("R3 copy / R11 result", {24'd0, dmem_wdata}, {24'd0, exp_v[i]});
                3'b011: chk("R4 complement / R11 result", {24'd0, dmem_wdata}, {24'd0, exp_v[i]});
                3'b100: chk("R5 add / R11 result", {24'd0, dmem_wdata}, {24'd0, exp_v[i]});
                default: chk("R6 subtract / R11 result", {24'd0, dmem_wdata}, {24'd0, exp_v[i]});
            endcase
            @(posedge clk);
            @(negedge clk);
            chk("R2 store step", {24'd0, imem_addr}, 32'd11 + 32'(2*i));
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            prog[i] = enc(1, 0, 0, 0);
            dmem[i] = 8'(i * 7);
        end
        do_reset();
        chk("R9 pc after reset", {24'd0, imem_addr}, 32'd0);

        // sweep every register op, every selector pair, several value sets
        for (int vs = 0; vs < 3; vs++) begin
            for (int i = 0; i < 4; i++) begin
                case (vs)
                    0: init_v[i] = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : (i == 2) ? 8'h80 : 8'h7F;
                    1: init_v[i] = (i == 0) ? 8'h01 : (i == 1) ? 8'hFE : (i == 2) ? 8'h55 : 8'hAA;
                    default: init_v[i] = 8'(37 * i + 91);
                endcase
            end
            for (int op = 0; op < 4; op++)
                for (int d = 0; d < 4; d++)
                    for (int s = 0; s < 4; s++)
                        run_case(1 + op / 2, op % 2, d, s);
        end

        // R9: reset in the middle of a run clears every register
        init_v[0] = 8'h11; init_v[1] = 8'h22; init_v[2] = 8'h33; init_v[3] = 8'h44;
        run_case(2, 0, 0, 1);
        for (int i = 0; i < 4; i++) begin
            prog[2*i]   = enc(0, 1, 0, i);
            prog[2*i+1] = 8'h90 + 8'(i);
        end
        do_reset();
        chk("R9 pc cleared", {24'd0, imem_addr}, 32'd0);
        for (int i = 0; i < 4; i++) begin
            chk("R9 register cleared", {24'd0, dmem_wdata}, 32'd0);
            @(posedge clk);
            @(negedge clk);
        end

        // R7 / R8: jump targets across the address range
        for (int t = 0; t < 256; t += 17) begin
            prog[0] = enc(3, 0, 0, 0);
            prog[1] = 8'(t);
            do_reset();
            chk("R10 no strobe on jump", {31'd0, dmem_we}, 32'd0);
            @(posedge clk);
            @(negedge clk);
            chk("R7 jump target", {24'd0, imem_addr}, 32'(t));
            for (int c = 0; c < 2; c++) begin
                prog[0] = enc(3, 1, 0, 0);
                do_reset();
                cond = 1'(c);
                @(posedge clk);
                @(negedge clk);
                chk("R8 conditional jump", {24'd0, imem_addr}, (c == 1) ? 32'(t) : 32'd2);
                cond = 1'b0;
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

endmodule